// File: doc/BRIEF.md
# Restorable Interface Scan Cell Array

This block is a short scan chain whose cells sit on the boundary between partitions of a design that is tested one partition at a time with broadside (launch-off-capture) delay patterns. Some cells are marked as interface cells by a parameter mask. Each interface cell has a shadow flip-flop that records the bit the cell was loaded with during shift. After the cell has taken part in a launch and a capture, the shadow bit is written back into it. The same loaded pattern can then be used for the test of the next partition without shifting it in again.

A small controller in the block generates the write-back pulse on chip. It needs only two flip-flops and watches the scan-enable input. After a shift, when scan-enable has been low for a launch edge and a capture edge, the third low edge is the restore edge. Functional data and capture enables come from outside. Each group of cells has its own capture enable, so a test can select which cells launch and capture. Cells outside the mask behave as ordinary mux-D scan cells and have no shadow.

Top module: `rsc_array`

## Requirements
- R1: While reset is high, every cell clears to 0 at the clock edge, so `cell_q` and `scan_out` read 0.
- R2: On each edge with `scan_en` high, cell 0 loads `scan_in` and cell i loads cell i-1. `scan_out` always equals the last cell, `cell_q[N_CELLS-1]`.
- R3: On an edge with `scan_en` low that is not a restore edge, cell i loads `func_d[i]` if `cap_en[i / CELLS_PER_GROUP]` is 1. Otherwise cell i keeps its value.
- R4: Each interface cell's shadow holds the value the cell took on the most recent shift edge.
- R5: The shadow does not change on edges with `scan_en` low. A restore therefore returns the value the cell held after shifting, whatever launch and capture loaded in the meantime.
- R6: After at least one shift edge, the third consecutive edge with `scan_en` low is the restore edge. It happens exactly once per low window: the fourth and later low edges are plain capture edges, and a window shorter than three edges has no restore.
- R7: On the restore edge, every interface cell loads its shadow value regardless of `func_d` and `cap_en`. Non-interface cells follow R3 on that edge.
- R8: Between reset and the first shift edge, no restore happens: every low edge follows R3 for all cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test and functional clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1 = shift, 0 = launch/capture window |
| scan_in | input | 1 | Serial data into cell 0 |
| func_d | input | N_CELLS | Functional data, one bit per cell |
| cap_en | input | N_GROUPS | Capture enable for each group of cells |
| scan_out | output | 1 | Serial data out of the last cell |
| cell_q | output | N_CELLS | Parallel values of all cells |

## Verification
The restore edge is the hardest case to reach and observe. It appears only on the third low edge after a shift, and it can be told apart from a capture only if the interface cells hold something other than their shifted bits just before it. The directed sequences therefore shift a pattern and then drive functional data that is the complement of that pattern on the launch and capture edges. Then they check that the interface cells jump back to the shifted bits while the plain cells keep capturing. Further sequences cut a low window after two edges, run low windows straight out of reset and enable only one group, to show that the pulse neither fires early, fires twice nor leaks into plain cells.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    // Operation applied to one scan cell on the next clock edge
    typedef enum logic [1:0] {
        CELL_HOLD    = 2'd0,
        CELL_SHIFT   = 2'd1,
        CELL_CAPTURE = 2'd2,
        CELL_RESTORE = 2'd3
    } cell_op_e;

    // Per-cell control bundle built by the top level
    typedef struct packed {
        cell_op_e op;
        logic     shift_d;
        logic     func_d;
    } cell_ctrl_t;

    // Position of the controller inside one low scan-enable window
    typedef enum logic [1:0] {
        WIN_ARMED    = 2'd0,
        WIN_LAUNCHED = 2'd1,
        WIN_CAPTURED = 2'd2,
        WIN_SPENT    = 2'd3
    } win_state_e;

    function automatic int unsigned group_of(input int unsigned idx,
                                             input int unsigned per_group);
        return idx / per_group;
    endfunction

endpackage

// File: rtl/rsc_restore_ctrl.sv
module rsc_restore_ctrl
    import rsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scan_en,
    output logic restore
);
    // Two flip-flops in total, shared by all interface cells
    win_state_e win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= WIN_SPENT;          // disarmed until a shift occurs
        end else if (scan_en) begin
            win_q <= WIN_ARMED;
        end else begin
            case (win_q)
                WIN_ARMED:    win_q <= WIN_LAUNCHED;
                WIN_LAUNCHED: win_q <= WIN_CAPTURED;
                default:      win_q <= WIN_SPENT;
            endcase
        end
    end

    // Pulse covers the edge that follows launch and capture
    assign restore = !scan_en && (win_q == WIN_CAPTURED);

endmodule

// File: rtl/rsc_iface_cell.sv
module rsc_iface_cell
    import rsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_ctrl_t ctrl,
    output logic       q,
    output logic       shadow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= 1'b0;
            shadow <= 1'b0;
        end else begin
            case (ctrl.op)
                CELL_SHIFT: begin
                    q      <= ctrl.shift_d;
                    shadow <= ctrl.shift_d;
                end
                CELL_CAPTURE: q <= ctrl.func_d;
                CELL_RESTORE: q <= shadow;
                default:      q <= q;
            endcase
        end
    end

endmodule

// File: rtl/rsc_plain_cell.sv
module rsc_plain_cell
    import rsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_ctrl_t ctrl,
    output logic       q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            case (ctrl.op)
                CELL_SHIFT:   q <= ctrl.shift_d;
                CELL_CAPTURE: q <= ctrl.func_d;
                default:      q <= q;
            endcase
        end
    end

endmodule

// File: rtl/rsc_array.sv
module rsc_array
    import rsc_pkg::*;
#(
    parameter int unsigned N_GROUPS        = 2,
    parameter int unsigned CELLS_PER_GROUP = 4,
    parameter logic [N_GROUPS*CELLS_PER_GROUP-1:0] IFACE_MASK = 8'hA5
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                scan_en,
    input  logic                                scan_in,
    input  logic [N_GROUPS*CELLS_PER_GROUP-1:0] func_d,
    input  logic [N_GROUPS-1:0]                 cap_en,
    output logic                                scan_out,
    output logic [N_GROUPS*CELLS_PER_GROUP-1:0] cell_q
);
    localparam int unsigned N_CELLS = N_GROUPS * CELLS_PER_GROUP;

    logic               restore_pulse;
    logic [N_CELLS:0]   chain;
    logic [N_CELLS-1:0] shadow_vec;

    rsc_restore_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .scan_en (scan_en),
        .restore (restore_pulse)
    );

    assign chain[0] = scan_in;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        localparam int unsigned GRP = group_of(i, CELLS_PER_GROUP);
        cell_ctrl_t ctrl;

        assign chain[i+1] = cell_q[i];

        always_comb begin
            ctrl.shift_d = chain[i];
            ctrl.func_d  = func_d[i];
            if (scan_en)
                ctrl.op = CELL_SHIFT;
            else if (IFACE_MASK[i] && restore_pulse)
                ctrl.op = CELL_RESTORE;
            else if (cap_en[GRP])
                ctrl.op = CELL_CAPTURE;
            else
                ctrl.op = CELL_HOLD;
        end

        if (IFACE_MASK[i]) begin : g_iface
            rsc_iface_cell u_cell (
                .clk    (clk),
                .rst    (rst),
                .ctrl   (ctrl),
                .q      (cell_q[i]),
                .shadow (shadow_vec[i])
            );
        end else begin : g_plain
            rsc_plain_cell u_cell (
                .clk  (clk),
                .rst  (rst),
                .ctrl (ctrl),
                .q    (cell_q[i])
            );
            assign shadow_vec[i] = 1'b0;
        end
    end

    assign scan_out = chain[N_CELLS];

endmodule

// File: rtl/rsc_array_chk.sv
module rsc_array_chk
    import rsc_pkg::*;
#(
    parameter int unsigned N_GROUPS        = 2,
    parameter int unsigned CELLS_PER_GROUP = 4,
    parameter logic [N_GROUPS*CELLS_PER_GROUP-1:0] IFACE_MASK = 8'hA5
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                scan_en,
    input logic                                scan_in,
    input logic [N_GROUPS*CELLS_PER_GROUP-1:0] func_d,
    input logic [N_GROUPS-1:0]                 cap_en,
    input logic [N_GROUPS*CELLS_PER_GROUP-1:0] cell_q,
    input logic [N_GROUPS*CELLS_PER_GROUP-1:0] shadow_vec,
    input logic                                restore
);
    localparam int unsigned N_CELLS = N_GROUPS * CELLS_PER_GROUP;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cell_q == '0));

    assert_shift_chain_R2: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> cell_q == {$past(cell_q[N_CELLS-2:0]), $past(scan_in)});

    assert_restore_single_R6: assert property (@(posedge clk) disable iff (rst)
        restore |=> !restore);

    assert_restore_window_R6: assert property (@(posedge clk) disable iff (rst)
        restore |-> ($past(!scan_en) && $past(!scan_en, 2)));

    assert_shadow_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> (shadow_vec == $past(shadow_vec)));

    for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
        localparam int unsigned GRP = group_of(i, CELLS_PER_GROUP);
        if (IFACE_MASK[i]) begin : g_if
            assert_shadow_track_R4: assert property (@(posedge clk) disable iff (rst)
                scan_en |=> (shadow_vec[i] == cell_q[i]));
            assert_restore_load_R7: assert property (@(posedge clk) disable iff (rst)
                restore |=> (cell_q[i] == $past(shadow_vec[i])));
            assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
                (!scan_en && !restore && cap_en[GRP]) |=> (cell_q[i] == $past(func_d[i])));
        end else begin : g_pl
            assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
                (!scan_en && cap_en[GRP]) |=> (cell_q[i] == $past(func_d[i])));
        end
    end

endmodule

bind rsc_array rsc_array_chk #(
    .N_GROUPS        (N_GROUPS),
    .CELLS_PER_GROUP (CELLS_PER_GROUP),
    .IFACE_MASK      (IFACE_MASK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scan_en    (scan_en),
    .scan_in    (scan_in),
    .func_d     (func_d),
    .cap_en     (cap_en),
    .cell_q     (cell_q),
    .shadow_vec (shadow_vec),
    .restore    (restore_pulse)
);

// File: tb/rsc_array_bench.sv
module rsc_array_bench;
    localparam int unsigned G   = 2;
    localparam int unsigned CPG = 4;
    localparam int unsigned N   = G * CPG;
    localparam logic [N-1:0] IFM = 8'hA5;

    logic         clk = 1'b0;
    logic         rst;
    logic         scan_en;
    logic         scan_in;
    logic [N-1:0] func_d;
    logic [G-1:0] cap_en;
    logic         scan_out;
    logic [N-1:0] cell_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench-side expectation, built from the requirements
    logic [N-1:0] exp_q;
    logic [N-1:0] exp_sh;
    int           low_edges;

    always #2 clk = ~clk;

    rsc_array #(.N_GROUPS(G), .CELLS_PER_GROUP(CPG), .IFACE_MASK(IFM)) u_rsc_array (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .func_d(func_d), .cap_en(cap_en), .scan_out(scan_out), .cell_q(cell_q)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic se, input logic sin, input logic [N-1:0] fd,
                        input logic [G-1:0] ce, input string tag);
        @(negedge clk);
        scan_en = se; scan_in = sin; func_d = fd; cap_en = ce;
        @(posedge clk);
        if (se) begin
            exp_q  = {exp_q[N-2:0], sin};
            exp_sh = exp_q & IFM;
            low_edges = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (IFM[i] && low_edges == 2) exp_q[i] = exp_sh[i];
                else if (ce[i / CPG])         exp_q[i] = fd[i];
            end
            if (low_edges < 3) low_edges++;
        end
        #1;
        check(tag, cell_q, exp_q);
        check({tag, " R2 scan_out"}, {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, exp_q[N-1]});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; scan_en = 1'b0; scan_in = 1'b0; func_d = '1; cap_en = '1;
        @(posedge clk); @(posedge clk);
        #1;
        exp_q = '0; exp_sh = '0; low_edges = 3;
        check("R1 reset", cell_q, '0);
        check("R1 scan_out", {{(N-1){1'b0}}, scan_out}, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic shift_pattern(input logic [N-1:0] pat);
        for (int k = N - 1; k >= 0; k--) tick(1'b1, pat[k], '0, '1, "R2 shift");
        check("R2 loaded", cell_q, pat);
    endtask

    // R8: low edges straight after reset never restore
    task automatic t_no_restore_after_reset();
        tick(1'b0, 1'b0, 8'hFF, 2'b11, "R8 R3");
        tick(1'b0, 1'b0, 8'h0F, 2'b11, "R8 R3");
        tick(1'b0, 1'b0, 8'hFF, 2'b11, "R8 third low edge");
        check("R8 all ones", cell_q, 8'hFF);
        tick(1'b0, 1'b0, 8'h33, 2'b11, "R8 R3");
    endtask

    // R5 R6 R7: full pass with complemented functional data
    task automatic t_full_pass();
        shift_pattern(8'h3C);
        tick(1'b0, 1'b0, 8'hC3, 2'b11, "R3 launch");
        tick(1'b0, 1'b0, 8'h5A, 2'b11, "R3 capture");
        tick(1'b0, 1'b0, 8'hFF, 2'b11, "R5 R7 restore");
        check("R7 iface restored", cell_q & IFM, 8'h3C & IFM);
        check("R7 plain captured", cell_q & ~IFM, 8'hFF & ~IFM);
        tick(1'b0, 1'b0, 8'h00, 2'b11, "R6 fourth edge captures");
        check("R6 no second restore", cell_q, 8'h00);
    endtask

    // R3 group select, R7 with gated plain cells
    task automatic t_group_pass();
        shift_pattern(8'hC5);
        tick(1'b0, 1'b0, 8'hFF, 2'b01, "R3 group0 only");
        check("R3 group1 held", cell_q & 8'hF0, 8'hC0);
        tick(1'b0, 1'b0, 8'h00, 2'b10, "R3 group1 only");
        tick(1'b0, 1'b0, 8'hAA, 2'b00, "R7 restore without enables");
        check("R7 iface restored", cell_q & IFM, 8'hC5 & IFM);
        tick(1'b0, 1'b0, 8'hAA, 2'b00, "R3 hold");
    endtask

    // R4 R6: short window, then new shift rearms and shadow follows it
    task automatic t_short_window();
        shift_pattern(8'h5A);
        tick(1'b0, 1'b0, 8'hFF, 2'b11, "R6 short launch");
        tick(1'b0, 1'b0, 8'h00, 2'b11, "R6 short capture");
        tick(1'b1, 1'b1, 8'h00, 2'b11, "R4 one shift");
        tick(1'b0, 1'b0, 8'hFF, 2'b11, "R6 launch");
        tick(1'b0, 1'b0, 8'hFF, 2'b11, "R6 capture");
        tick(1'b0, 1'b0, 8'hFF, 2'b11, "R4 restore of new shift");
        check("R4 iface value", cell_q & IFM, 8'h01 & IFM);
    endtask

    initial begin
        do_reset();
        t_no_restore_after_reset();
        t_full_pass();
        t_group_pass();
        t_short_window();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule